// File: doc/BRIEF.md
# Two-Entry Data Address Translation Cache with Hardware Refill

This block translates 32-bit virtual data addresses into 32-bit physical addresses using 4 KiB pages. It keeps two translations, and any translation can sit in either slot. Both slots are compared in parallel. On a hit, the physical address comes out in the same cycle with no stall, and the matching slot becomes the most recently used. The low 12 address bits are never translated.

On a miss, a built-in walker reads the page table entry from a page table held in physical memory. It holds the requester in stall for exactly ten cycles. It then installs the entry in the least recently used slot, or in an empty slot if one exists. The request then completes as a hit on the following cycle.

The requester holds its request and address stable until it sees ready. A fetched entry without its valid bit is not installed. Instead, a one-cycle error pulse is raised and the requester is expected to drop the request.

Top module: `dtlb_walk`

## Requirements
- R1: When ready_o is high, paddr_o[11:0] equals req_vaddr_i[11:0].
- R2: After reset no slot holds a translation, so the first request to any page misses and stalls.
- R3: A miss holds stall_o high for exactly 10 consecutive cycles (parameter REFILL_CYCLES). With the request held, ready_o rises in the cycle right after the last stall cycle and carries the new translation.
- R4: While stall_o is high, pt_rd_en_o is high and pt_rd_addr_o equals PT_BASE + 4 * req_vaddr_i[31:12].
- R5: A request that hits raises ready_o in the same cycle, with stall_o and pt_rd_en_o low.
- R6: A refill fills an empty slot first; otherwise it replaces the least recently used slot. Both hits and refills count as uses.
- R7: If the fetched entry has bit 20 clear, fault_o is high for one cycle, in the cycle after the last stall cycle, and nothing is installed. A repeated request to that page misses again.
- R8: ready_o and stall_o are never high together, and both are low while req_valid_i is low.
- R9: The page table entry format is bit 20 = valid and bits 19:0 = physical page number. The translated address is {PPN, req_vaddr_i[11:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request, held until ready_o |
| req_vaddr_i | input | 32 | Virtual address of the request |
| paddr_o | output | 32 | Translated physical address, valid with ready_o |
| ready_o | output | 1 | Translation available this cycle |
| stall_o | output | 1 | Requester must wait (refill in progress) |
| fault_o | output | 1 | Fetched entry was invalid; nothing installed |
| pt_rd_en_o | output | 1 | Page table read enable |
| pt_rd_addr_o | output | 32 | Physical address of the page table entry |
| pt_rd_data_i | input | 21 | Entry read back: bit 20 valid, bits 19:0 PPN |

## Verification
The main stimulus is an address stream over pages 1, 2 and 3, mapped to physical pages 2, 3 and 5. The stream interleaves repeat accesses with accesses to new pages. Comparing which requests stall against which return at once shows whether recency is refreshed by hits as well as by refills, and whether the victim is the least recent slot rather than a fixed one. Offsets at both ends of a page show that the low bits pass through unchanged. A page whose upper address bits are all set, mapped to a wide page number, exposes truncated fields. An unmapped page that is requested twice shows that a bad entry is neither installed nor able to disturb the live slots.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VPN_W  = ADDR_W - OFF_W;
  localparam int unsigned PPN_W  = ADDR_W - OFF_W;
  localparam int unsigned PTE_W  = PPN_W + 1;  // valid bit on top

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_slot_t;
endpackage

// File: rtl/dtlb_cam.sv
module dtlb_cam
  import dtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 2,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] look_vpn_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic [ENTRIES-1:0] valid_o
);
  tlb_slot_t          slot_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))
        slot_q[g] <= '{valid: 1'b1, vpn: wr_vpn_i, ppn: wr_ppn_i};
    end
    assign match[g]   = slot_q[g].valid && slot_q[g].vpn == look_vpn_i;
    assign valid_o[g] = slot_q[g].valid;
  end

  always_comb begin
    hit_idx_o = '0;
    hit_ppn_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx_o = IDX_W'(i);
        hit_ppn_o = slot_q[i].ppn;
      end
    end
  end
  assign hit_o = |match;
endmodule

// File: rtl/dtlb_lru.sv
module dtlb_lru #(
  parameter int unsigned ENTRIES = 2,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_en_i,
  input  logic [IDX_W-1:0]   touch_idx_i,
  input  logic [ENTRIES-1:0] valid_i,
  output logic [IDX_W-1:0]   victim_o
);
  // age 0 = most recent, ENTRIES-1 = least recent; ages stay a permutation
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx_i];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q[g] <= IDX_W'(g);
      else if (touch_en_i) begin
        if (touch_idx_i == IDX_W'(g))  age_q[g] <= '0;
        else if (age_q[g] < touched_age) age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_i[i]) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && age_q[i] == IDX_W'(ENTRIES - 1)) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtlb_walker.sv
module dtlb_walker
  import dtlb_pkg::*;
#(
  parameter int unsigned         REFILL_CYCLES = 10,
  parameter logic [ADDR_W-1:0]   PT_BASE       = 32'h0010_0000,
  localparam int unsigned CNT_W = $clog2(REFILL_CYCLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [PTE_W-1:0]  pte_i,
  output logic              busy_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              install_o,
  output logic [PPN_W-1:0]  install_ppn_o,
  output logic              fault_o
);
  typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
  walk_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done;
  logic             fault_q;

  // first stall cycle is the miss cycle itself, rest spent in ST_WALK
  assign busy_o    = (st_q == ST_WALK);
  assign done      = busy_o && cnt_q == CNT_W'(REFILL_CYCLES - 2);
  assign rd_en_o   = miss_i || busy_o;
  assign rd_addr_o = PT_BASE + {vpn_i, 2'b00};
  assign install_o     = done && pte_i[PPN_W];
  assign install_ppn_o = pte_i[PPN_W-1:0];
  assign fault_o   = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= done && !pte_i[PPN_W];
      case (st_q)
        ST_IDLE: if (miss_i) begin
          st_q  <= ST_WALK;
          cnt_q <= '0;
        end
        ST_WALK: begin
          if (done) st_q <= ST_IDLE;
          else      cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtlb_walk.sv
module dtlb_walk
  import dtlb_pkg::*;
#(
  parameter int unsigned       ENTRIES       = 2,
  parameter int unsigned       REFILL_CYCLES = 10,
  parameter logic [31:0]       PT_BASE       = 32'h0010_0000,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_vaddr_i,
  output logic [31:0] paddr_o,
  output logic        ready_o,
  output logic        stall_o,
  output logic        fault_o,
  output logic        pt_rd_en_o,
  output logic [31:0] pt_rd_addr_o,
  input  logic [20:0] pt_rd_data_i
);
  logic [VPN_W-1:0]   vpn;
  logic               hit, busy, miss, install, hit_ok;
  logic [IDX_W-1:0]   hit_idx, victim, touch_idx;
  logic [PPN_W-1:0]   hit_ppn, new_ppn;
  logic [ENTRIES-1:0] valid_vec;

  assign vpn    = req_vaddr_i[ADDR_W-1:OFF_W];
  assign hit_ok = req_valid_i && hit && !busy;
  assign miss   = req_valid_i && !hit && !busy;

  dtlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk_i, .rst_ni,
    .look_vpn_i(vpn),
    .wr_en_i(install), .wr_idx_i(victim), .wr_vpn_i(vpn), .wr_ppn_i(new_ppn),
    .hit_o(hit), .hit_idx_o(hit_idx), .hit_ppn_o(hit_ppn), .valid_o(valid_vec)
  );

  assign touch_idx = install ? victim : hit_idx;

  dtlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i, .rst_ni,
    .touch_en_i(hit_ok || install), .touch_idx_i(touch_idx),
    .valid_i(valid_vec), .victim_o(victim)
  );

  dtlb_walker #(.REFILL_CYCLES(REFILL_CYCLES), .PT_BASE(PT_BASE)) u_walker (
    .clk_i, .rst_ni,
    .miss_i(miss), .vpn_i(vpn), .pte_i(pt_rd_data_i),
    .busy_o(busy), .rd_en_o(pt_rd_en_o), .rd_addr_o(pt_rd_addr_o),
    .install_o(install), .install_ppn_o(new_ppn), .fault_o(fault_o)
  );

  assign paddr_o = {hit_ppn, req_vaddr_i[OFF_W-1:0]};
  assign ready_o = hit_ok;
  assign stall_o = miss || busy;
endmodule

// File: rtl/dtlb_walk_chk.sv
module dtlb_walk_chk #(
  parameter int unsigned REFILL_CYCLES = 10,
  parameter logic [31:0] PT_BASE       = 32'h0010_0000,
  localparam int unsigned RUN_W = $clog2(REFILL_CYCLES + 2) + 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_vaddr_i,
  input logic [31:0] paddr_o,
  input logic        ready_o,
  input logic        stall_o,
  input logic        fault_o,
  input logic        pt_rd_en_o,
  input logic [31:0] pt_rd_addr_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (stall_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  assert_offset_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> paddr_o[11:0] == req_vaddr_i[11:0]);
  assert_stall_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> run_q < RUN_W'(REFILL_CYCLES));
  assert_stall_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> run_q == RUN_W'(REFILL_CYCLES));
  assert_walk_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> pt_rd_en_o && pt_rd_addr_o == PT_BASE + {req_vaddr_i[31:12], 2'b00});
  assert_hit_no_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !pt_rd_en_o && !stall_o);
  assert_fault_after_walk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(stall_o) && !$past(fault_o));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i && !$past(stall_o) |-> !ready_o && !stall_o);
endmodule

bind dtlb_walk dtlb_walk_chk #(.REFILL_CYCLES(REFILL_CYCLES), .PT_BASE(PT_BASE)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_vaddr_i, .paddr_o,
  .ready_o, .stall_o, .fault_o, .pt_rd_en_o, .pt_rd_addr_o
);

// File: tb/tb_dtlb_walk.sv
module tb_dtlb_walk;
  localparam int          CLK_PERIOD = 10;
  localparam int          REFILL     = 10;
  localparam logic [31:0] BASE       = 32'h0010_0000;
  localparam int          NVEC       = 10;

  // address stream: LRU behaviour over pages 1,2,3 (R6)
  localparam logic [31:0] VEC_VA [NVEC] = '{
    32'h0000_1234, 32'h0000_1FFC, 32'h0000_2010, 32'h0000_1008, 32'h0000_3ABC,
    32'h0000_1000, 32'h0000_2000, 32'h0000_1FFF, 32'h0000_3004, 32'h0000_1444};
  localparam logic [31:0] VEC_PA [NVEC] = '{
    32'h0000_2234, 32'h0000_2FFC, 32'h0000_3010, 32'h0000_2008, 32'h0000_5ABC,
    32'h0000_2000, 32'h0000_3000, 32'h0000_2FFF, 32'h0000_5004, 32'h0000_2444};
  localparam logic        VEC_MISS [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                              1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] paddr, pt_addr;
  logic        ready, stall, fault, pt_en;
  logic [20:0] pt_data;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // page table in memory: bit 20 valid, bits 19:0 PPN (R9)
  always_comb begin
    logic [31:0] idx;
    idx = (pt_addr - BASE) >> 2;
    case (idx)
      32'h1:     pt_data = {1'b1, 20'h00002};
      32'h2:     pt_data = {1'b1, 20'h00003};
      32'h3:     pt_data = {1'b1, 20'h00005};
      32'hFFFFF: pt_data = {1'b1, 20'hABCDE};
      default:   pt_data = {1'b0, 20'h12345};
    endcase
  end

  dtlb_walk #(.REFILL_CYCLES(REFILL), .PT_BASE(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .paddr_o(paddr), .ready_o(ready), .stall_o(stall), .fault_o(fault),
    .pt_rd_en_o(pt_en), .pt_rd_addr_o(pt_addr), .pt_rd_data_i(pt_data));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 time unit later; returns stall count
  task automatic run_req(input logic [31:0] va, input bit exp_fault,
                         output int nstall, output bit got_ready, output bit got_fault,
                         output logic [31:0] pa);
    bit addr_ok = 1'b1;
    nstall = 0; got_ready = 0; got_fault = 0; pa = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (exp_fault && fault) begin got_fault = 1; break; end
      if (ready) begin got_ready = 1; pa = paddr; break; end
      if (stall) begin
        nstall++;
        if (!pt_en || pt_addr != BASE + {va[31:12], 2'b00}) addr_ok = 0;
      end
      @(negedge clk);
    end
    if (nstall > 0) check(addr_ok, "R4 walk read address", pt_addr, BASE + {va[31:12], 2'b00});
    if (!got_fault) @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  initial begin
    int ns; bit rdy, flt; logic [31:0] pa;
    #(CLK_PERIOD * 2 + 3);
    // reset state
    check(!ready && !stall && !fault, "R8 reset outputs quiet", {ready, stall, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!ready && !stall && !pt_en, "R8 idle without request", {ready, stall, pt_en}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_req(VEC_VA[v], 0, ns, rdy, flt, pa);
      // first access misses: R2; miss length R3; hit without stall R5; victim choice R6
      check(ns == (VEC_MISS[v] ? REFILL : 0),
            VEC_MISS[v] ? "R3 R6 R2 miss stall length" : "R5 R6 hit with no stall",
            ns, VEC_MISS[v] ? REFILL : 0);
      check(rdy && pa == VEC_PA[v], "R1 R9 translated address", pa, VEC_PA[v]);
    end

    // unmapped page: fault, not installed (R7)
    run_req(32'h0000_7000, 1, ns, rdy, flt, pa);
    check(flt && ns == REFILL, "R7 fault after full refill", {flt, 8'(ns)}, {1'b1, 8'(REFILL)});
    check(!stall && !ready, "R8 quiet after request drop", {stall, ready}, 0);
    @(negedge clk); #1;
    check(!fault, "R7 fault lasts one cycle", fault, 0);
    run_req(32'h0000_7000, 1, ns, rdy, flt, pa);
    check(flt && ns == REFILL, "R7 faulting page not installed", ns, REFILL);
    run_req(32'h0000_1444, 0, ns, rdy, flt, pa);
    check(ns == 0 && pa == 32'h0000_2444, "R7 live slots untouched", pa, 32'h0000_2444);
    run_req(32'h0000_3FFF, 0, ns, rdy, flt, pa);
    check(ns == 0 && pa == 32'h0000_5FFF, "R6 R1 page 3 still resident", pa, 32'h0000_5FFF);

    // wide page number (R9)
    run_req(32'hFFFF_F123, 0, ns, rdy, flt, pa);
    check(ns == REFILL && pa == 32'hABCD_E123, "R9 wide PPN translation", pa, 32'hABCD_E123);
    run_req(32'hFFFF_FFFF, 0, ns, rdy, flt, pa);
    check(ns == 0 && pa == 32'hABCD_EFFF, "R1 R5 top offset hit", pa, 32'hABCD_EFFF);

    // async reset clears slots (R2)
    @(negedge clk); rst_n = 1'b0; #2; rst_n = 1'b1;
    run_req(32'h0000_1000, 0, ns, rdy, flt, pa);
    check(ns == REFILL, "R2 slots empty after reset", ns, REFILL);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule